// File: doc/BRIEF.md
# Parallel Decoder-Matrix Histogram Counter

This block keeps a running histogram of 8-bit item values. On each clock it accepts a bus of several item lanes. Each lane has its own valid bit. Every lane drives a private one-hot decoder, so the lanes together form a bit matrix with one column per lane and one row per possible value. Each row is reduced by a popcount to the number of lanes that carried that value in the cycle. That small sum is then added to the value's count register. All 256 bins update on the same clock edge, so the block takes a full bus of items every cycle, even when every lane carries the same value.

Each counter saturates at its largest value and does not wrap. It then raises a sticky per-bin overflow flag. A synchronous clear empties the whole histogram, and it wins over any input in the same cycle. Software-side or downstream logic reads one bin at a time through an addressed port with a single cycle of latency.

Top module: `hist_decoder_counter`

## Requirements
- R1: While reset is held, and until the first input after reset, every bin reads back a count of 0 with its overflow flag at 0, and the read outputs are 0.
- R2: Each lane whose valid bit is 1 adds exactly one to the bin whose index equals that lane's 8-bit item (lane k occupies bits [8k+7:8k] of the item bus). Lanes with valid 0 add nothing, whatever their item bits hold.
- R3: When several valid lanes carry the same value in one cycle, that bin grows by the number of such lanes. This can be up to LANES per cycle. All bins touched in a cycle update on the same edge.
- R4: A cycle with clr at 1 sets every count and every overflow flag to 0 on the next edge. Valid lanes presented in that same cycle are discarded.
- R5: A count never exceeds 2^CNT_W-1. An increment that would pass that value leaves the count at 2^CNT_W-1, and later increments keep it there.
- R6: A bin's overflow flag becomes 1 only when an increment would exceed 2^CNT_W-1. Landing exactly on the maximum does not set it. Once set, it stays at 1 until clr or reset.
- R7: rd_count and rd_ovf show the bin selected by rd_addr one cycle after the address is presented. They include every update committed on earlier edges, but not input presented in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of all bins and flags |
| in_valid | input | LANES | Per-lane valid bits |
| in_items | input | LANES*8 | Lane items, lane k at bits [8k+7:8k] |
| rd_addr | input | 8 | Bin index to read |
| rd_count | output | CNT_W | Count of the addressed bin, one cycle later |
| rd_ovf | output | 1 | Overflow flag of the addressed bin, one cycle later |

## Verification
On every cycle, the assertions check that each decoder column is one-hot or empty. They also check that the row sums added together equal the number of valid lanes, that a clear empties a bin, and that a saturated count holds. A raised overflow flag must stay up and must appear only at the maximum count. Whether the right bin receives each item, and the exact counts after mixed random bursts and all-lanes-equal bursts, can only be shown by the bench's scenarios, which compare every bin to a reference histogram. The same goes for the read latency and whether it includes same-cycle input, and for the boundary between landing exactly on the maximum and overflowing past it.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int ITEM_W = 8;
  localparam int BINS   = 1 << ITEM_W;

  // width of a popcount over 'lanes' bits
  function automatic int sum_width(input int lanes);
    return $clog2(lanes + 1);
  endfunction
endpackage

// File: rtl/hist_rst_sync.sv
module hist_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/hist_lane_decoder.sv
module hist_lane_decoder
  import hist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ITEM_W-1:0] item,
  output logic [BINS-1:0]   column
);
  always_comb begin
    column = '0;
    if (valid) column[item] = 1'b1;
  end

  // R2: a column marks at most one value, and an idle lane marks none
  a_r2_column_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(column));
  a_r2_idle_lane_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (column == '0));
endmodule

// File: rtl/hist_row_sum.sv
module hist_row_sum #(
  parameter int LANES = 8,
  parameter int SUM_W = 4
) (
  input  logic [LANES-1:0] row,
  output logic [SUM_W-1:0] sum
);
  always_comb begin
    sum = '0;
    for (int l = 0; l < LANES; l++) begin
      sum = sum + SUM_W'(row[l]);
    end
  end
endmodule

// File: rtl/hist_bin.sv
module hist_bin #(
  parameter int CNT_W = 16,
  parameter int SUM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SUM_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W:0]   wide_sum;
  logic [CNT_W-1:0] cnt_d;
  logic             ovf_d;
  logic             upd_en;

  always_comb begin
    wide_sum = {1'b0, cnt_q} + (CNT_W + 1)'(inc);
    upd_en   = clr | (inc != '0);
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (wide_sum[CNT_W]) begin
      cnt_d = CNT_MAX;
      ovf_d = 1'b1;
    end else begin
      cnt_d = wide_sum[CNT_W-1:0];
      ovf_d = ovf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  // R4: clear empties the bin on the next edge
  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0) && !ovf_q);
  // R5: a saturated count holds
  a_r5_sat_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) && !clr |=> (cnt_q == CNT_MAX));
  // R6: overflow flag is sticky and only seen at the maximum
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !clr |=> ovf_q);
  a_r6_ovf_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> (cnt_q == CNT_MAX));
endmodule

// File: rtl/hist_decoder_counter.sv
module hist_decoder_counter
  import hist_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [LANES-1:0]        in_valid,
  input  logic [LANES*ITEM_W-1:0] in_items,
  input  logic [ITEM_W-1:0]       rd_addr,
  output logic [CNT_W-1:0]        rd_count,
  output logic                    rd_ovf
);
  localparam int SUM_W = sum_width(LANES);
  localparam int TOT_W = ITEM_W + SUM_W;

  if (CNT_W < 8 || CNT_W > 32 || (CNT_W % 4) != 0) begin : g_bad_width
    $error("CNT_W must be 8..32 in steps of 4");
  end

  logic rst_sync_n;

  hist_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [LANES-1:0][BINS-1:0]  col;
  logic [BINS-1:0][LANES-1:0]  row;
  logic [BINS-1:0][SUM_W-1:0]  inc;
  logic [BINS-1:0][CNT_W-1:0]  cnt;
  logic [BINS-1:0]             ovf;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    hist_lane_decoder u_dec (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .valid  (in_valid[l]),
      .item   (in_items[l*ITEM_W +: ITEM_W]),
      .column (col[l])
    );
  end

  for (genvar b = 0; b < BINS; b++) begin : g_bin
    for (genvar l = 0; l < LANES; l++) begin : g_tap
      assign row[b][l] = col[l][b];
    end

    hist_row_sum #(.LANES(LANES), .SUM_W(SUM_W)) u_sum (
      .row (row[b]),
      .sum (inc[b])
    );

    hist_bin #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_bin (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clr),
      .inc   (inc[b]),
      .cnt_q (cnt[b]),
      .ovf_q (ovf[b])
    );
  end

  // read port: registered select
  logic [CNT_W-1:0] rd_count_d;
  logic             rd_ovf_d;

  always_comb begin
    rd_count_d = cnt[rd_addr];
    rd_ovf_d   = ovf[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_count <= '0;
      rd_ovf   <= 1'b0;
    end else begin
      rd_count <= rd_count_d;
      rd_ovf   <= rd_ovf_d;
    end
  end

  // R2: the row sums together account for every valid lane, no more
  logic [TOT_W-1:0] inc_total;
  always_comb begin
    inc_total = '0;
    for (int b = 0; b < BINS; b++) begin
      inc_total = inc_total + TOT_W'(inc[b]);
    end
  end

  a_r2_total_matches_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    inc_total == TOT_W'($countones(in_valid)));
endmodule

// File: tb/sim_hist_decoder_counter.sv
module sim_hist_decoder_counter;
  localparam int LANES = 8;
  localparam int CNT_W = 16;
  localparam longint MAXV = (longint'(1) << CNT_W) - 1;

  logic                 clk;
  logic                 rst_n;
  logic                 clr;
  logic [LANES-1:0]     in_valid;
  logic [LANES*8-1:0]   in_items;
  logic [7:0]           rd_addr;
  logic [CNT_W-1:0]     rd_count;
  logic                 rd_ovf;

  hist_decoder_counter #(.LANES(LANES), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
    .in_items(in_items), .rd_addr(rd_addr), .rd_count(rd_count), .rd_ovf(rd_ovf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int     n_checks = 0;
  int     n_errors = 0;
  longint ref_cnt [256];
  bit     ref_ovf [256];

  function automatic longint sat_add(input longint a, input longint b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  function automatic bit will_overflow(input longint a, input longint b);
    return (a + b > MAXV);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ref_clear();
    for (int i = 0; i < 256; i++) begin
      ref_cnt[i] = 0;
      ref_ovf[i] = 1'b0;
    end
  endtask

  // one cycle of input; called and returns at a falling edge
  task automatic step(input logic [LANES-1:0] v, input logic [LANES*8-1:0] it,
                      input logic c);
    longint add [256];
    in_valid = v; in_items = it; clr = c;
    @(negedge clk);
    if (c) ref_clear();
    else begin
      for (int i = 0; i < 256; i++) add[i] = 0;
      for (int l = 0; l < LANES; l++)
        if (v[l]) add[it[l*8 +: 8]]++;
      for (int i = 0; i < 256; i++) begin
        if (add[i] != 0) begin
          if (will_overflow(ref_cnt[i], add[i])) ref_ovf[i] = 1'b1;
          ref_cnt[i] = sat_add(ref_cnt[i], add[i]);
        end
      end
    end
    in_valid = '0; clr = 1'b0;
  endtask

  task automatic read_chk(input int a, input string req);
    rd_addr = 8'(a);
    @(negedge clk);
    chk(req, rd_count, ref_cnt[a]);
    chk(req, rd_ovf, ref_ovf[a]);
  endtask

  task automatic sweep(input string req);
    in_valid = '0; clr = 1'b0;
    for (int a = 0; a < 256; a++) read_chk(a, req);
  endtask

  function automatic logic [LANES*8-1:0] all_same(input logic [7:0] val);
    logic [LANES*8-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*8 +: 8] = val;
    return r;
  endfunction

  function automatic logic [LANES*8-1:0] rand_items();
    logic [LANES*8-1:0] r;
    for (int l = 0; l < LANES; l++) r[l*8 +: 8] = 8'($urandom_range(255));
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [LANES*8-1:0] it;
    longint old, nfull, rem;
    void'($urandom(32'h1234_5678));
    ref_clear();
    rst_n = 1'b0; clr = 1'b0; in_valid = '0; in_items = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 in reset", rd_count, 0);
    chk("R1 in reset", rd_ovf, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sweep("R1 after reset");

    // R2: lone lanes, invalid lanes carry garbage
    it = rand_items();
    it[7:0] = 8'h00; it[(LANES-1)*8 +: 8] = 8'hFF;
    step({1'b1, {(LANES-2){1'b0}}, 1'b1}, it, 1'b0);
    step('0, all_same(8'h3C), 1'b0);
    sweep("R2 single lanes");

    // R3: all lanes the same value
    step('1, all_same(8'hA5), 1'b0);
    step('1, all_same(8'hA5), 1'b0);
    read_chk(8'hA5, "R3 all lanes equal");

    // R2/R3: random bursts, some with all lanes equal
    for (int c = 0; c < 300; c++) begin
      if (c % 25 == 0) step('1, all_same(8'($urandom_range(255))), 1'b0);
      else step(LANES'($urandom), rand_items(), 1'b0);
    end
    sweep("R2 R3 random bursts");

    // R7: same-cycle input not visible, then visible
    old = ref_cnt[8'h33];
    rd_addr = 8'h33; in_valid = '1; in_items = all_same(8'h33);
    @(negedge clk);
    in_valid = '0;
    chk("R7 same-cycle excluded", rd_count, old);
    ref_cnt[8'h33] = sat_add(old, LANES);
    @(negedge clk);
    chk("R7 next cycle included", rd_count, ref_cnt[8'h33]);

    // R4: clear wins over valid input
    step('1, all_same(8'h33), 1'b1);
    sweep("R4 clear priority");

    // R5/R6: saturation at the boundary
    nfull = MAXV / LANES;
    rem = MAXV - nfull * LANES;
    for (longint i = 0; i < nfull; i++) step('1, all_same(8'h55), 1'b0);
    if (rem != 0) step(LANES'((1 << rem) - 1), all_same(8'h55), 1'b0);
    read_chk(8'h55, "R6 exact max no overflow");
    chk("R6 exact max", rd_count, MAXV);
    step(LANES'(1), all_same(8'h55), 1'b0);
    read_chk(8'h55, "R5 R6 overflow");
    chk("R6 flag raised", rd_ovf, 1);
    step('1, all_same(8'h55), 1'b0);
    step('0, all_same(8'h55), 1'b0);
    read_chk(8'h55, "R5 holds R6 sticky");
    read_chk(8'h56, "R5 neighbour untouched");

    // R4: clear drops the overflow flag
    step('0, '0, 1'b1);
    read_chk(8'h55, "R4 clear drops overflow");
    step('1, all_same(8'h55), 1'b0);
    read_chk(8'h55, "R4 counting resumes");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule